// File: doc/BRIEF.md
# Receive Word Read-Out Sequencer

This block delivers received packet data to a host one 32-bit word per read. Packets are held back to back in a circular data store. A second circular queue holds one word count per packet. A producer fills both stores: it pushes data words, and it pushes a count together with the last word of each packet. A packet occupies ceil((bytes + start byte offset)/4) words plus one more word for its trailing CRC. Bytes sit little-endian within each word.

The sequencer frames each packet in the host's read stream. It returns a programmable number of zero words before the first data word. It returns zero pad words after the last data word, so that the packet's total word span ends on a 4-word or 8-word boundary. The host can discard the rest of a packet with a skip command. A dump command drains everything. A read made when there is nothing left to deliver returns zero and raises a sticky error flag.

Top module: `rx_readout_seq`

## Requirements
- R1: After reset, rd_data is 0, used_words is 0 and rx_err is 0.
- R2: A push_en cycle with free space appends push_word to the data store and raises used_words by one. Data words are returned in the order they were pushed.
- R3: When no packet is open and no offset or pad word is pending, the next read (or skip) takes the oldest entry of the length queue. lead_off and end_align are sampled in that cycle only, and later changes do not affect the open packet.
- R4: A packet opened with lead_off = k returns k zero words before its first data word.
- R5: end_align code 1 adds zero words after the data until lead_off + length is a multiple of 4. Code 2 pads to a multiple of 8. Codes 0 and 3 add no pad words.
- R6: Offset and pad reads return zero and leave used_words unchanged. Each data-word read lowers used_words by one.
- R7: A read with no open packet, no pending offset or pad, and an empty length queue returns 0 and sets rx_err. rx_err stays set until an err_clr cycle with no new underflow.
- R8: skip_req clears any pending offset and pad and drops every remaining data word of the open packet. If no packet is open, it first opens the next queued one. A skip returns no word: rd_data keeps its value, and skip takes priority over a read in the same cycle.
- R9: dump_req empties the data store and the length queue and closes any open packet. A push in the same cycle is discarded.
- R10: rd_data changes only in the cycle after an accepted read (rd_en with neither skip_req nor dump_req) and holds otherwise.
- R11: used_words never exceeds FIFO_DEPTH, and pushes into a full store are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Append push_word to the data store |
| push_word | input | 32 | Data word from the producer |
| len_push | input | 1 | Append len_words to the length queue |
| len_words | input | CW | Word count of the completed packet (at least 1) |
| rd_en | input | 1 | Host read strobe, one word per cycle |
| lead_off | input | 3 | Leading zero words per packet |
| end_align | input | 2 | End-alignment code (0/3 none, 1 four words, 2 eight words) |
| skip_req | input | 1 | Discard the rest of the current packet |
| dump_req | input | 1 | Empty all stored data and lengths |
| err_clr | input | 1 | Clear the underflow flag |
| rd_data | output | 32 | Word returned by the last accepted read |
| rx_err | output | 1 | Sticky underflow flag |
| used_words | output | CW | Data words held in the store |

## Verification
Directed packets are read with lead offsets of 0, 1, 2 and 3 and with every alignment code. Their lengths are chosen so that the pad counts differ (three, five and none), which separates the 4-word and 8-word rules from each other and from no padding. Skips are issued in three places: inside a packet's data, while no packet is open, and while offset words are still pending. These show whether the pointer advances by the remaining length and whether the pending zeros are dropped. A long random phase mixes reads, pushes, skips and mid-packet changes of the configuration fields, all against a queue-based model. A fill past capacity followed by a dump exercises the wrap and full limits.

// File: rtl/rx_readout_pkg.sv
package rx_readout_pkg;

   typedef enum logic [1:0] {
      ALN_NONE = 2'd0,
      ALN_QUAD = 2'd1,
      ALN_OCT  = 2'd2,
      ALN_RSVD = 2'd3
   } align_e;

   // Zero words needed so that total becomes a multiple of the chosen span.
   function automatic logic [2:0] calc_pad(input int unsigned total, input logic [1:0] code);
      int unsigned neg;
      neg = ~total + 1;
      case (align_e'(code))
         ALN_QUAD: return 3'(neg & 32'd3);
         ALN_OCT:  return 3'(neg & 32'd7);
         default:  return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/rxs_ring.sv
module rxs_ring #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1),
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic [CW-1:0]    drop_n,
   output logic [WIDTH-1:0] head_data,
   output logic [CW-1:0]    count
);

   localparam bit POW2 = (DEPTH == (1 << AW));
   localparam int SW   = CW + 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxs_ring: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CW-1:0]    cnt;
   logic             push_ok;

   assign push_ok   = push && (cnt != CW'(DEPTH)) && !flush;
   assign head_data = mem[rd_ptr];
   assign count     = cnt;

   if (POW2) begin : g_wrap_free
      assign rd_nxt = rd_ptr + AW'(drop_n);
      assign wr_nxt = wr_ptr + AW'(1);
   end else begin : g_wrap_cmp
      logic [SW-1:0] rd_sum;
      assign rd_sum = SW'(rd_ptr) + SW'(drop_n);
      assign rd_nxt = (rd_sum >= SW'(DEPTH)) ? AW'(rd_sum - SW'(DEPTH)) : AW'(rd_sum);
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else if (flush) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (drop_n != '0) rd_ptr <= rd_nxt;
         if (push_ok)      wr_ptr <= wr_nxt;
         cnt <= cnt + CW'(push_ok) - drop_n;
      end
   end

endmodule

// File: rtl/rxs_seq.sv
module rxs_seq
   import rx_readout_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LW     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              skip_req,
   input  logic              dump_req,
   input  logic              err_clr,
   input  logic [2:0]        lead_off,
   input  logic [1:0]        end_align,
   input  logic              len_avail,
   input  logic [LW-1:0]     len_head,
   input  logic [DATA_W-1:0] data_head,
   output logic              len_pop,
   output logic [LW-1:0]     data_drop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_err
);

   logic [LW-1:0]     sz_q, sz_d, e_sz;
   logic [2:0]        off_q, off_d, e_off;
   logic [2:0]        pad_q, pad_d, e_pad;
   logic              idle, start, take, err_set;
   logic [DATA_W-1:0] word;

   assign idle  = (sz_q == '0) && (off_q == '0) && (pad_q == '0);
   assign start = idle && len_avail && (rd_en || skip_req) && !dump_req;
   assign e_sz  = start ? len_head : sz_q;
   assign e_off = start ? lead_off : off_q;
   assign e_pad = start ? calc_pad(32'(lead_off) + 32'(len_head), end_align) : pad_q;
   assign len_pop = start;

   always_comb begin
      sz_d      = e_sz;
      off_d     = e_off;
      pad_d     = e_pad;
      data_drop = '0;
      word      = '0;
      take      = 1'b0;
      err_set   = 1'b0;
      if (dump_req) begin
         sz_d  = '0;
         off_d = '0;
         pad_d = '0;
      end else if (skip_req) begin
         data_drop = e_sz;
         sz_d      = '0;
         off_d     = '0;
         pad_d     = '0;
      end else if (rd_en) begin
         take = 1'b1;
         if (e_off != '0) begin
            off_d = e_off - 3'd1;
         end else if (e_sz != '0) begin
            word      = data_head;
            data_drop = LW'(1);
            sz_d      = e_sz - LW'(1);
         end else if (e_pad != '0) begin
            pad_d = e_pad - 3'd1;
         end else begin
            err_set = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sz_q    <= '0;
         off_q   <= '0;
         pad_q   <= '0;
         rd_data <= '0;
         rx_err  <= 1'b0;
      end else begin
         sz_q  <= sz_d;
         off_q <= off_d;
         pad_q <= pad_d;
         if (take)         rd_data <= word;
         if (err_set)      rx_err  <= 1'b1;
         else if (err_clr) rx_err  <= 1'b0;
      end
   end

endmodule

// File: rtl/rx_readout_seq.sv
module rx_readout_seq #(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 2640,
   parameter int LQ_DEPTH   = 64,
   localparam int CW   = $clog2(FIFO_DEPTH + 1),
   localparam int LQCW = $clog2(LQ_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_en,
   input  logic [DATA_W-1:0] push_word,
   input  logic              len_push,
   input  logic [CW-1:0]     len_words,
   input  logic              rd_en,
   input  logic [2:0]        lead_off,
   input  logic [1:0]        end_align,
   input  logic              skip_req,
   input  logic              dump_req,
   input  logic              err_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rx_err,
   output logic [CW-1:0]     used_words
);

   if (DATA_W != 32) begin : g_bad_width
      $error("rx_readout_seq: host words are 32 bits wide");
   end

   logic [DATA_W-1:0] data_head;
   logic [CW-1:0]     len_head, data_drop;
   logic [LQCW-1:0]   lq_cnt;
   logic              len_pop;

   rxs_ring #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) data_ring_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (dump_req),
      .push      (push_en),
      .push_data (push_word),
      .drop_n    (data_drop),
      .head_data (data_head),
      .count     (used_words)
   );

   rxs_ring #(.WIDTH(CW), .DEPTH(LQ_DEPTH)) len_ring_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (dump_req),
      .push      (len_push),
      .push_data (len_words),
      .drop_n    (LQCW'(len_pop)),
      .head_data (len_head),
      .count     (lq_cnt)
   );

   rxs_seq #(.DATA_W(DATA_W), .LW(CW)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .skip_req  (skip_req),
      .dump_req  (dump_req),
      .err_clr   (err_clr),
      .lead_off  (lead_off),
      .end_align (end_align),
      .len_avail (lq_cnt != '0),
      .len_head  (len_head),
      .data_head (data_head),
      .len_pop   (len_pop),
      .data_drop (data_drop),
      .rd_data   (rd_data),
      .rx_err    (rx_err)
   );

endmodule

// File: rtl/rx_readout_seq_chk.sv
module rx_readout_seq_chk #(
   parameter int DEPTH = 2640,
   parameter int CW    = 12
) (
   input logic        clk,
   input logic        rst_n,
   input logic        push_en,
   input logic        rd_en,
   input logic        skip_req,
   input logic        dump_req,
   input logic        err_clr,
   input logic [31:0] rd_data,
   input logic        rx_err,
   input logic [CW-1:0] used_words
);

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_en || skip_req || dump_req) |=> $stable(rd_data));

   // R7
   err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_err) |-> $past(rd_en));

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_err) |-> $past(err_clr));

   // R9
   dump_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dump_req |=> (used_words == '0));

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      used_words <= CW'(DEPTH));

   // R6
   one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!skip_req && !dump_req) |=> (int'(used_words) + 1 >= int'($past(used_words))));

   // R2
   no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !push_en |=> (used_words <= $past(used_words)));

endmodule

bind rx_readout_seq rx_readout_seq_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_en    (push_en),
   .rd_en      (rd_en),
   .skip_req   (skip_req),
   .dump_req   (dump_req),
   .err_clr    (err_clr),
   .rd_data    (rd_data),
   .rx_err     (rx_err),
   .used_words (used_words)
);

// File: tb/rx_readout_seq_tb.sv
module rx_readout_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 2640;
   localparam int LQD        = 64;
   localparam int CW         = $clog2(DEPTH + 1);
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_en = 1'b0, len_push = 1'b0, rd_en = 1'b0;
   logic          skip_req = 1'b0, dump_req = 1'b0, err_clr = 1'b0;
   logic [31:0]   push_word = '0;
   logic [CW-1:0] len_words = '0;
   logic [2:0]    lead_off = '0;
   logic [1:0]    end_align = '0;
   logic [31:0]   rd_data;
   logic          rx_err;
   logic [CW-1:0] used_words;

   int    total = 0, bad = 0, cyc = 0;
   bit    done = 1'b0;
   string phase = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_readout_seq dut_i (
      .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_word(push_word),
      .len_push(len_push), .len_words(len_words), .rd_en(rd_en),
      .lead_off(lead_off), .end_align(end_align), .skip_req(skip_req),
      .dump_req(dump_req), .err_clr(err_clr), .rd_data(rd_data),
      .rx_err(rx_err), .used_words(used_words)
   );

   // Behavioural reference: plain queues and counters.
   int unsigned dq[$];
   int unsigned lq[$];
   int unsigned m_sz, m_off, m_pad, m_data;
   bit          m_err;

   function automatic int unsigned ref_pad(int unsigned tot, int unsigned code);
      if (code == 1) return ((tot + 3) / 4) * 4 - tot;
      if (code == 2) return ((tot + 7) / 8) * 8 - tot;
      return 0;
   endfunction

   always @(posedge clk) begin
      int unsigned dold, lold;
      bit eset;
      eset = 0;
      if (!rst_n) begin
         dq.delete(); lq.delete();
         m_sz = 0; m_off = 0; m_pad = 0; m_data = 0; m_err = 0;
      end else begin
         dold = dq.size();
         lold = lq.size();
         if (dump_req) begin
            dq.delete(); lq.delete();
            m_sz = 0; m_off = 0; m_pad = 0;
         end else begin
            if (m_sz == 0 && m_off == 0 && m_pad == 0 && lold != 0 && (rd_en || skip_req)) begin
               m_sz  = lq.pop_front();
               m_off = lead_off;
               m_pad = ref_pad(m_off + m_sz, end_align);
            end
            if (skip_req) begin
               repeat (m_sz) void'(dq.pop_front());
               m_sz = 0; m_off = 0; m_pad = 0;
            end else if (rd_en) begin
               if (m_off > 0) begin m_off--; m_data = 0; end
               else if (m_sz > 0) begin m_data = dq.pop_front(); m_sz--; end
               else if (m_pad > 0) begin m_pad--; m_data = 0; end
               else begin m_data = 0; eset = 1; end
            end
            if (push_en && dold < DEPTH) dq.push_back(push_word);
            if (len_push && lold < LQD) lq.push_back(len_words);
         end
         if (eset) m_err = 1;
         else if (err_clr) m_err = 0;
      end
   end

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (rd_data != m_data || rx_err != m_err || int'(used_words) != dq.size()) begin
            bad++;
            $display("FAIL %s cycle %0d: act data=%h err=%0d used=%0d exp data=%h err=%0d used=%0d",
                     phase, cyc, rd_data, rx_err, used_words, m_data, m_err, dq.size());
         end
      end
   end

   task automatic check(string tag, int unsigned act, int unsigned exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic push_pkt(int n, int unsigned base);
      for (int i = 0; i < n; i++) begin
         push_en = 1; push_word = base + i;
         len_push = (i == n - 1); len_words = CW'(n);
         @(negedge clk);
      end
      push_en = 0; len_push = 0;
   endtask

   task automatic read_one(string tag, int unsigned exp);
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      check(tag, rd_data, exp);
   endtask

   task automatic pulse_skip();
      skip_req = 1;
      @(negedge clk);
      skip_req = 0;
   endtask

   task automatic clear_err();
      err_clr = 1;
      @(negedge clk);
      err_clr = 0;
      check("R7 clear", rx_err, 0);
   endtask

   task automatic finish_run();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG && !done) begin
         bad++;
         $display("FAIL R10 watchdog: act cycles=%0d exp below %0d", cyc, WATCHDOG);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      phase = "R1";
      check("R1 data", rd_data, 0);
      check("R1 used", used_words, 0);
      check("R1 err", rx_err, 0);

      // R2 plain packet, no offset, no alignment
      phase = "R2";
      push_pkt(3, 'h100);
      check("R2 used", used_words, 3);
      read_one("R2 w0", 'h100);
      read_one("R2 w1", 'h101);
      read_one("R2 w2", 'h102);
      check("R2 drained", used_words, 0);

      // R4 / R3 offset sampled at packet start only
      phase = "R4";
      lead_off = 3'd2;
      push_pkt(2, 'h200);
      read_one("R4 off0", 0);
      lead_off = 3'd0;
      read_one("R3 off1 kept", 0);
      check("R6 used after offsets", used_words, 2);
      read_one("R4 d0", 'h200);
      read_one("R4 d1", 'h201);

      // R5 align to 4: 1 + 4 = 5, pad 3
      phase = "R5";
      lead_off = 3'd1; end_align = 2'd1;
      push_pkt(4, 'h300);
      read_one("R5 off", 0);
      for (int i = 0; i < 4; i++) read_one("R5 data", 'h300 + i);
      for (int i = 0; i < 3; i++) read_one("R5 pad4", 0);
      check("R6 used after pad", used_words, 0);
      check("R5 no extra pad err", rx_err, 0);
      phase = "R7";
      read_one("R7 underflow data", 0);
      check("R7 err set", rx_err, 1);
      clear_err();

      // R5 align to 8: 0 + 3, pad 5
      phase = "R5";
      lead_off = 3'd0; end_align = 2'd2;
      push_pkt(3, 'h400);
      for (int i = 0; i < 3; i++) read_one("R5 data8", 'h400 + i);
      for (int i = 0; i < 5; i++) read_one("R5 pad8", 0);
      check("R5 pad8 no err", rx_err, 0);
      // code 3: no padding
      end_align = 2'd3;
      push_pkt(2, 'h500);
      read_one("R5 c3 d0", 'h500);
      read_one("R5 c3 d1", 'h501);
      read_one("R5 c3 no pad", 0);
      check("R5 code3 underflow", rx_err, 1);
      clear_err();
      end_align = 2'd0;

      // R8 skip inside data
      phase = "R8";
      push_pkt(5, 'h600);
      push_pkt(2, 'h700);
      read_one("R8 a0", 'h600);
      read_one("R8 a1", 'h601);
      pulse_skip();
      check("R8 used after skip", used_words, 2);
      check("R8 rd_data held", rd_data, 'h601);
      read_one("R8 next pkt", 'h700);
      read_one("R8 next pkt w1", 'h701);
      // skip with no open packet drops the whole next packet
      push_pkt(3, 'h800);
      push_pkt(1, 'h900);
      pulse_skip();
      check("R8 idle skip used", used_words, 1);
      read_one("R8 after idle skip", 'h900);
      // skip while offset pending
      lead_off = 3'd3;
      push_pkt(2, 'hA00);
      read_one("R8 offset word", 0);
      pulse_skip();
      check("R8 offset skip used", used_words, 0);
      lead_off = 3'd0;
      read_one("R8 nothing left", 0);
      check("R8 pending zeros dropped", rx_err, 1);
      clear_err();

      // R9 dump with a simultaneous push
      phase = "R9";
      push_pkt(4, 'hB00);
      dump_req = 1; push_en = 1; push_word = 'hDEAD;
      @(negedge clk);
      dump_req = 0; push_en = 0;
      check("R9 used", used_words, 0);
      read_one("R9 empty read", 0);
      check("R9 lengths gone", rx_err, 1);
      clear_err();

      // R11 fill past capacity
      phase = "R11";
      push_en = 1;
      for (int i = 0; i < DEPTH + 5; i++) begin
         push_word = 'h1000 + i;
         @(negedge clk);
      end
      push_en = 0;
      check("R11 full count", used_words, DEPTH);
      dump_req = 1;
      @(negedge clk);
      dump_req = 0;

      // R3 random mix against the model
      phase = "R3";
      begin
         int pend;
         pend = 0;
         for (int i = 0; i < 4000; i++) begin
            rd_en     = ($urandom_range(0, 1) == 1);
            skip_req  = ($urandom_range(0, 40) == 0);
            err_clr   = ($urandom_range(0, 20) == 0);
            lead_off  = 3'($urandom_range(0, 7));
            end_align = 2'($urandom_range(0, 3));
            push_en   = ($urandom_range(0, 2) != 0);
            push_word = $urandom;
            len_push  = 0;
            if (push_en) pend++;
            if (pend > 0 && $urandom_range(0, 5) == 0) begin
               len_push  = 1;
               len_words = CW'(pend);
               pend = 0;
            end
            @(negedge clk);
         end
         rd_en = 0; skip_req = 0; push_en = 0; len_push = 0; err_clr = 0;
         @(negedge clk);
      end

      finish_run();
   end

endmodule